// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide register face of a classic serial port. A host reaches eight byte offsets through a 3-bit address with separate read and write strobes. The block keeps the divisor, line settings, modem control bits, a scratch byte, the receive holding byte and the line status flags. It decodes the line settings into frame-format outputs and derives the bit rate from the divisor. It swaps single bytes with a character back end, and that back end can report that it is full. The interrupt identification logic sits in a separate block and takes its status flags and pulses from here.

A latch-select bit in the line settings register (bit 7) remaps offsets 0 and 1 onto the two divisor bytes. A small state machine turns each divisor update into a rate (115200 / divisor) by restoring division, one quotient bit per cycle. Its states are `RATE_IDLE` (waiting), `RATE_RUN` (one quotient bit per cycle) and `RATE_LOAD` (publishing the quotient). Its transitions are: IDLE to RUN on a divisor update with a nonzero divisor; RUN to LOAD after the last quotient bit; LOAD to IDLE. A new divisor update during RUN or LOAD restarts RUN if the divisor is nonzero and returns to IDLE if it is zero. A zero divisor never reaches LOAD, so the published rate is left alone.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status byte at offset 5 reads 0x60 (bit 6 transmitter empty, bit 5 holding empty, all else clear), and the rate output is 0.
- R2: With bit 7 of the line settings set, offsets 0 and 1 read and write the low and high divisor bytes. With bit 7 clear, offset 1 is the interrupt enable register, which keeps only bits 3:0 and drives `int_en`.
- R3: With bit 7 clear, a write to offset 0 while holding-empty is set gives a one-cycle `tx_valid` with the byte on `tx_byte` in the cycle after the strobe. While holding-empty is clear, the write is dropped.
- R4: With bit 7 clear, a read of offset 0 returns the receive byte and clears data-ready (status bit 0) and break-indicator (status bit 4) on that edge.
- R5: The line settings decode as follows: `data_len` = bits 1:0 + 5; `two_stop` = bit 2; `parity_en` = bit 3; `parity_even` = bit 4.
- R6: `brk_on` follows bit 6 of the line settings. `brk_chg` pulses for one cycle only on a write that changes that bit.
- R7: Offset 7 is a read/write scratch byte. Offset 4 keeps only bits 4:0, with `rts_out` = bit 1 and `dtr_out` = bit 0. Writes to offsets 2, 5 and 6 change nothing, and offsets 2 and 6 read 0.
- R8: An offered byte (`rx_valid`) is taken, `rx_accept` is high and data-ready is set only while data-ready is clear. Otherwise the receive byte is left unchanged.
- R9: While `be_full` is high, holding-empty is cleared. On its falling edge, holding-empty and transmitter-empty are set and `thr_pend` pulses for one cycle.
- R10: Within 30 cycles of a divisor write, `rate` equals 115200 divided by the divisor. A write that leaves the divisor at zero does not change `rate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| tx_valid | output | 1 | Byte offered to back end |
| tx_byte | output | 8 | Byte to back end |
| be_full | input | 1 | Back end cannot take bytes |
| rx_valid | input | 1 | Back end offers a byte |
| rx_byte | input | 8 | Offered byte |
| rx_accept | output | 1 | Offered byte taken this cycle |
| rx_break | input | 1 | Back end saw a break |
| brk_on | output | 1 | Break level requested |
| brk_chg | output | 1 | Break request changed |
| rts_out | output | 1 | Request-to-send level |
| dtr_out | output | 1 | Terminal-ready level |
| int_en | output | 4 | Interrupt enables |
| data_len | output | 4 | Data bits per frame |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity |
| rate | output | 17 | Bit rate from divisor |
| data_ready | output | 1 | Receive byte unread |
| thr_empty | output | 1 | Holding empty flag |
| tx_empty | output | 1 | Transmitter empty flag |
| break_ind | output | 1 | Break indicator flag |
| thr_pend | output | 1 | Transmit-pending pulse |

## Verification
A stuck or wrongly set status flag is visible at offset 5 and on the flag outputs one edge after the event that should have moved it. That event can be a byte offer, a read of offset 0, or an edge of `be_full`. A wrong latch-select state shows at once as a divisor byte read where data was expected, or as a missing `tx_valid` on the next cycle. A bad divider state or count shows as a wrong or missing `rate` value once the division time has passed, at most about twenty cycles after the divisor write.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    typedef enum logic [2:0] {
        OFS_DATA  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_IDENT = 3'd2,
        OFS_LCTL  = 3'd3,
        OFS_MCTL  = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SCR   = 3'd7
    } ofs_e;

    typedef enum logic [1:0] {
        RATE_IDLE = 2'd0,
        RATE_RUN  = 2'd1,
        RATE_LOAD = 2'd2
    } rate_state_e;
endpackage

// File: rtl/uart_rf_lcr.sv
module uart_rf_lcr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lcr_wr,
    input  logic [7:0] wdata,
    output logic [7:0] lcr,
    output logic       dlab,
    output logic [3:0] data_len,
    output logic       two_stop,
    output logic       parity_en,
    output logic       parity_even,
    output logic       brk_on,
    output logic       brk_chg
);
    logic [7:0] lcr_q;
    logic       chg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q <= 8'h00;
            chg_q <= 1'b0;
        end else begin
            chg_q <= lcr_wr && (wdata[6] != lcr_q[6]);
            if (lcr_wr) lcr_q <= wdata;
        end
    end

    always_comb begin
        lcr         = lcr_q;
        dlab        = lcr_q[7];
        data_len    = 4'd5 + {2'b00, lcr_q[1:0]};
        two_stop    = lcr_q[2];
        parity_en   = lcr_q[3];
        parity_even = lcr_q[4];
        brk_on      = lcr_q[6];
        brk_chg     = chg_q;
    end

    // R6: a pulse only when the break bit moved, and every move pulses
    a_r6_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        brk_chg |-> (lcr_q[6] != $past(lcr_q[6])));
    a_r6_change_means_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_q[6] != $past(lcr_q[6])) |-> brk_chg);
endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_break,
    input  logic       rbr_read,
    input  logic       be_full,
    output logic       rx_accept,
    output logic [7:0] rbr,
    output logic       dr,
    output logic       bi,
    output logic       thre,
    output logic       temt,
    output logic       thr_pend
);
    logic [7:0] rbr_q;
    logic       dr_q, bi_q, thre_q, temt_q, full_q, pend_q;
    logic       full_fall;

    always_comb begin
        rx_accept = rx_valid && !dr_q;
        full_fall = full_q && !be_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr_q  <= 8'h00;
            dr_q   <= 1'b0;
            bi_q   <= 1'b0;
            thre_q <= 1'b1;
            temt_q <= 1'b1;
            full_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            full_q <= be_full;
            pend_q <= full_fall;
            if (rbr_read) begin
                dr_q <= 1'b0;
                bi_q <= 1'b0;
            end
            if (rx_accept) begin
                rbr_q <= rx_byte;
                dr_q  <= 1'b1;
            end
            if (rx_break) bi_q <= 1'b1;
            if (be_full) begin
                thre_q <= 1'b0;
            end else if (full_fall) begin
                thre_q <= 1'b1;
                temt_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rbr      = rbr_q;
        dr       = dr_q;
        bi       = bi_q;
        thre     = thre_q;
        temt     = temt_q;
        thr_pend = pend_q;
    end

    // R8: an unread byte is never overwritten
    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_q && rx_valid) |=> $stable(rbr_q));
    // R4: reading a pending byte clears data-ready
    a_r4_read_clears_dr: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_read && dr_q) |=> !dr_q);
    // R9: full back end means holding register not empty
    a_r9_full_clears_thre: assert property (@(posedge clk) disable iff (!rst_n)
        be_full |=> !thre_q);
    a_r9_pend_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        thr_pend |-> (thre_q && temt_q));
endmodule

// File: rtl/uart_rf_rate.sv
module uart_rf_rate
    import uart_rf_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int BASE_RATE = 115200,
    parameter int RATE_W    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  divisor,
    output logic [RATE_W-1:0] rate
);
    localparam int CNT_W = $clog2(RATE_W + 1);
    localparam logic [RATE_W-1:0] BASE = RATE_W'(BASE_RATE);

    rate_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [DIV_W:0]     rem_q, rem_sh, rem_nx;
    logic [RATE_W-1:0]  num_q, quo_q, rate_q;
    logic [DIV_W-1:0]   div_q;
    logic               ge;

    always_comb begin
        rem_sh = {rem_q[DIV_W-1:0], num_q[RATE_W-1]};
        ge     = rem_sh >= {1'b0, div_q};
        rem_nx = ge ? (rem_sh - {1'b0, div_q}) : rem_sh;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RATE_IDLE: if (start && divisor != '0) state_d = RATE_RUN;
            RATE_RUN: begin
                if (start) state_d = (divisor != '0) ? RATE_RUN : RATE_IDLE;
                else if (cnt_q == CNT_W'(RATE_W - 1)) state_d = RATE_LOAD;
            end
            RATE_LOAD: state_d = (start && divisor != '0) ? RATE_RUN : RATE_IDLE;
            default:   state_d = RATE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RATE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rem_q <= '0;
            num_q <= '0;
            quo_q <= '0;
            div_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            rem_q <= '0;
            num_q <= BASE;
            quo_q <= '0;
            div_q <= divisor;
        end else if (state_q == RATE_RUN) begin
            cnt_q <= cnt_q + 1'b1;
            rem_q <= rem_nx;
            num_q <= num_q << 1;
            quo_q <= {quo_q[RATE_W-2:0], ge};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      rate_q <= '0;
        else if (state_q == RATE_LOAD)   rate_q <= quo_q;
    end

    assign rate = rate_q;

    // R10: a zero divisor leaves the published rate alone
    a_r10_zero_keeps_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (start && divisor == '0 && state_q != RATE_LOAD) |=> $stable(rate_q));
    a_r10_run_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RATE_RUN) |-> (div_q != '0));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int BASE_RATE = 115200,
    parameter int RATE_W    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              be_full,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_accept,
    input  logic              rx_break,
    output logic              brk_on,
    output logic              brk_chg,
    output logic              rts_out,
    output logic              dtr_out,
    output logic [3:0]        int_en,
    output logic [3:0]        data_len,
    output logic              two_stop,
    output logic              parity_en,
    output logic              parity_even,
    output logic [RATE_W-1:0] rate,
    output logic              data_ready,
    output logic              thr_empty,
    output logic              tx_empty,
    output logic              break_ind,
    output logic              thr_pend
);
    localparam int HI_W = DIV_W - 8;

    ofs_e             ofs;
    logic             dlab, thre, temt, dr, bi;
    logic [7:0]       lcr, rbr, dll_q, scr_q, tx_byte_q;
    logic [HI_W-1:0]  dlm_q;
    logic [3:0]       ier_q;
    logic [4:0]       mcr_q;
    logic             tx_valid_q, div_start_q;
    logic             wr_data, wr_ien, wr_lctl, rbr_read;

    always_comb begin
        ofs      = ofs_e'(reg_addr);
        wr_data  = reg_wr && (ofs == OFS_DATA);
        wr_ien   = reg_wr && (ofs == OFS_IEN);
        wr_lctl  = reg_wr && (ofs == OFS_LCTL);
        rbr_read = reg_rd && (ofs == OFS_DATA) && !dlab;
    end

    uart_rf_lcr u_lcr (
        .clk(clk), .rst_n(rst_n), .lcr_wr(wr_lctl), .wdata(reg_wdata),
        .lcr(lcr), .dlab(dlab), .data_len(data_len), .two_stop(two_stop),
        .parity_en(parity_en), .parity_even(parity_even),
        .brk_on(brk_on), .brk_chg(brk_chg)
    );

    uart_rf_status u_status (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .rbr_read(rbr_read), .be_full(be_full),
        .rx_accept(rx_accept), .rbr(rbr), .dr(dr), .bi(bi),
        .thre(thre), .temt(temt), .thr_pend(thr_pend)
    );

    uart_rf_rate #(.DIV_W(DIV_W), .BASE_RATE(BASE_RATE), .RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .start(div_start_q),
        .divisor({dlm_q, dll_q}), .rate(rate)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_q       <= '0;
            dlm_q       <= '0;
            ier_q       <= '0;
            mcr_q       <= '0;
            scr_q       <= '0;
            tx_byte_q   <= '0;
            tx_valid_q  <= 1'b0;
            div_start_q <= 1'b0;
        end else begin
            tx_valid_q  <= wr_data && !dlab && thre;
            div_start_q <= (wr_data || wr_ien) && dlab;
            if (wr_data && !dlab && thre) tx_byte_q <= reg_wdata;
            if (wr_data && dlab)  dll_q <= reg_wdata;
            if (wr_ien && dlab)   dlm_q <= reg_wdata[HI_W-1:0];
            if (wr_ien && !dlab)  ier_q <= reg_wdata[3:0];
            if (reg_wr && ofs == OFS_MCTL) mcr_q <= reg_wdata[4:0];
            if (reg_wr && ofs == OFS_SCR)  scr_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        unique case (ofs)
            OFS_DATA:  reg_rdata = dlab ? dll_q : rbr;
            OFS_IEN:   reg_rdata = dlab ? 8'(dlm_q) : {4'h0, ier_q};
            OFS_IDENT: reg_rdata = 8'h00;
            OFS_LCTL:  reg_rdata = lcr;
            OFS_MCTL:  reg_rdata = {3'b000, mcr_q};
            OFS_LSTAT: reg_rdata = {1'b0, temt, thre, bi, 3'b000, dr};
            OFS_MSTAT: reg_rdata = 8'h00;
            OFS_SCR:   reg_rdata = scr_q;
            default:   reg_rdata = 8'h00;
        endcase
    end

    always_comb begin
        tx_valid   = tx_valid_q;
        tx_byte    = tx_byte_q;
        rts_out    = mcr_q[1];
        dtr_out    = mcr_q[0];
        int_en     = ier_q;
        data_ready = dr;
        thr_empty  = thre;
        tx_empty   = temt;
        break_ind  = bi;
    end

    // R3: nothing is sent when holding-empty is clear
    a_r3_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !dlab && !thre) |=> !tx_valid);
    // R2: divisor writes never reach the back end
    a_r2_latch_no_send: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && dlab) |=> !tx_valid);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !$past(wr_data)) |-> 1'b0);
endmodule

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        tx_valid, be_full = 1'b0, rx_valid = 1'b0, rx_accept, rx_break = 1'b0;
    logic [7:0]  tx_byte, rx_byte = '0;
    logic        brk_on, brk_chg, rts_out, dtr_out, two_stop, parity_en, parity_even;
    logic [3:0]  int_en, data_len;
    logic [16:0] rate;
    logic        data_ready, thr_empty, tx_empty, break_ind, thr_pend;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    uart_regfront u_uart_regfront (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .be_full(be_full), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_accept(rx_accept),
        .rx_break(rx_break), .brk_on(brk_on), .brk_chg(brk_chg), .rts_out(rts_out),
        .dtr_out(dtr_out), .int_en(int_en), .data_len(data_len), .two_stop(two_stop),
        .parity_en(parity_en), .parity_even(parity_even), .rate(rate),
        .data_ready(data_ready), .thr_empty(thr_empty), .tx_empty(tx_empty),
        .break_ind(break_ind), .thr_pend(thr_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // strobe set at a falling edge, taken at the next rising edge, released after
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd5, v);
        chk("R1 status after reset", v, 8'h60);
        chk("R1 rate after reset", rate, 0);
        chk("R1 no send after reset", tx_valid, 0);
    endtask

    task automatic t_divisor;
        logic [7:0] v;
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h0C);
        wr(3'd1, 8'h00);
        rd(3'd0, v); chk("R2 divisor low", v, 8'h0C);
        rd(3'd1, v); chk("R2 divisor high", v, 8'h00);
        idle(30);
        chk("R10 rate 115200/12", rate, 9600);
        wr(3'd0, 8'h00);
        idle(30);
        chk("R10 zero divisor keeps rate", rate, 9600);
        wr(3'd0, 8'h03);
        idle(30);
        chk("R10 rate 115200/3", rate, 38400);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        idle(30);
        chk("R10 rate 115200/256", rate, 450);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R2 enable register low nibble", v, 8'h0F);
        chk("R2 int_en", int_en, 4'hF);
        wr(3'd3, 8'h83);
        rd(3'd1, v); chk("R2 divisor high kept", v, 8'h01);
        wr(3'd3, 8'h03);
    endtask

    task automatic t_lcr;
        wr(3'd3, 8'h1F);
        chk("R5 len 8", data_len, 8);
        chk("R5 two stop", two_stop, 1);
        chk("R5 parity on", parity_en, 1);
        chk("R5 even", parity_even, 1);
        wr(3'd3, 8'h00);
        chk("R5 len 5", data_len, 5);
        chk("R5 all clear", {two_stop, parity_en, parity_even}, 0);
    endtask

    task automatic t_break;
        wr(3'd3, 8'h40);
        chk("R6 pulse on set", brk_chg, 1);
        chk("R6 level set", brk_on, 1);
        @(negedge clk);
        chk("R6 pulse one cycle", brk_chg, 0);
        wr(3'd3, 8'h43);
        chk("R6 no pulse without change", brk_chg, 0);
        wr(3'd3, 8'h03);
        chk("R6 pulse on clear", brk_chg, 1);
        chk("R6 level clear", brk_on, 0);
    endtask

    task automatic t_tx;
        logic [7:0] v;
        wr(3'd0, 8'hA5);
        chk("R3 send valid", tx_valid, 1);
        chk("R3 send byte", tx_byte, 8'hA5);
        @(negedge clk);
        chk("R3 send one cycle", tx_valid, 0);
        be_full = 1'b1;
        @(negedge clk);
        rd(3'd5, v); chk("R9 full clears holding empty", v, 8'h40);
        wr(3'd0, 8'h5A);
        chk("R3 dropped when full", tx_valid, 0);
        be_full = 1'b0;
        @(negedge clk);
        chk("R9 pending pulse", thr_pend, 1);
        @(negedge clk);
        chk("R9 pending one cycle", thr_pend, 0);
        rd(3'd5, v); chk("R9 flags set again", v, 8'h60);
    endtask

    task automatic t_rx;
        logic [7:0] v;
        @(negedge clk);
        rx_byte = 8'h3C; rx_valid = 1'b1;
        #5 chk("R8 accept when empty", rx_accept, 1);
        @(negedge clk);
        rx_byte = 8'h77;
        #5 chk("R8 refuse when full", rx_accept, 0);
        @(negedge clk);
        rx_valid = 1'b0;
        rd(3'd5, v); chk("R8 data ready", v, 8'h61);
        rd(3'd0, v); chk("R8 first byte kept", v, 8'h3C);
        rd(3'd5, v); chk("R4 read clears ready", v, 8'h60);
        @(negedge clk);
        rx_break = 1'b1;
        @(negedge clk);
        rx_break = 1'b0;
        rd(3'd5, v); chk("R4 break indicated", v, 8'h70);
        rd(3'd0, v);
        rd(3'd5, v); chk("R4 read clears break", v, 8'h60);
    endtask

    task automatic t_misc;
        logic [7:0] v;
        wr(3'd7, 8'h9E);
        rd(3'd7, v); chk("R7 scratch", v, 8'h9E);
        wr(3'd4, 8'hFF);
        rd(3'd4, v); chk("R7 modem low 5 bits", v, 8'h1F);
        chk("R7 rts dtr on", {rts_out, dtr_out}, 2'b11);
        wr(3'd4, 8'h01);
        chk("R7 dtr only", {rts_out, dtr_out}, 2'b01);
        wr(3'd2, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        rd(3'd5, v); chk("R7 status unchanged", v, 8'h60);
        rd(3'd3, v); chk("R7 line settings unchanged", v, 8'h03);
        rd(3'd7, v); chk("R7 scratch unchanged", v, 8'h9E);
        rd(3'd2, v); chk("R7 offset 2 reads 0", v, 8'h00);
        rd(3'd6, v); chk("R7 offset 6 reads 0", v, 8'h00);
        chk("R7 no send", tx_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divisor();
        t_lcr();
        t_break();
        t_tx();
        t_rx();
        t_misc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule